// File: doc/BRIEF.md
# Cascade Frame Header Stage

This block is one stage of a daisy chain of serial-loaded devices. A host clocks a frame into the first stage one bit per clock, MSB first, on `sdi`, with a load strobe `ld_in`. The frame starts with a 24-bit header: an 8-bit sync word (0xE8), a 6-bit command field in which a 2-bit command is sent three times in a row, and a 10-bit fault tally. The payload bits follow the header. The stage takes the leading part of the payload for itself. It passes on the header and the rest of the payload on `sdo`/`ld_out`, in the same format, to the next stage.

While the strobe is low, the stage scans the incoming stream for the sync word. It then checks that the strobe rose close to the first command bit and that the three command copies agree. If the selected local fault input is active, it adds one to the fault tally before the header leaves. A 24-bit delay line holds the header for as long as it takes to make that change. The line stays frozen while the local payload is taken in, so the forwarded frame is contiguous and shorter than the received frame by exactly this stage's share. The host reads the summed tally from the last stage of the chain.

Top module: `chain_header_stage`

## Requirements
- R1: After reset, `sdo`, `ld_out`, `frame_vld` and `frame_err` are 0 and `cmd_out` is 0.
- R2: The sync word 0xE8 starts a frame only if `ld_in` was low three clocks before the clock in which the stage sees the last sync bit. If the strobe is already high through the sync word, the frame causes neither `frame_vld` nor `frame_err`.
- R3: Frame bits are numbered 0 onward from the first sync bit, and bit 8 is the first command bit. A frame is accepted if `ld_in` first goes high during bit 7, 8 or 9. If it first goes high during bit 6 or bit 10, the stage pulses `frame_err` and does not produce `frame_vld`.
- R4: Header bits 8..13 are C1,C0,C1,C0,C1,C0. If the three pairs differ, the stage pulses `frame_err` and drops the frame.
- R5: The command C1:C0 selects the local payload length: 00 uses PAY_PWM, 01 uses PAY_CAL, 10 uses PAY_GLB and 11 uses PAY_CFG. When the last local bit has been taken in, `frame_vld` pulses for one clock. In that clock `cmd_out` holds C1:C0 and `pay_data` holds the N local bits right-aligned, with the first received bit at position N-1 and zeros above.
- R6: The forwarded tally (header bits 14..23) equals the received tally plus one when the selected fault input is high and the received tally is below 1023. Otherwise it is unchanged. C0=0 selects `fault_hot` and C0=1 selects `fault_open`.
- R7: The forwarded stream starts on `sdo` in the clock of `frame_vld`. It is the 24-bit header (sync and command unchanged), followed without a gap by the payload bits that come after the local share.
- R8: `ld_out` is high from the clock in which forwarded header bit 8 is on `sdo` through the clock that carries the last forwarded bit. That last bit is the one that arrived in the last clock in which `ld_in` was high.
- R9: If `ld_in` drops after sync but before the local payload is complete, the stage pulses `frame_err` and produces no `frame_vld` and no forwarded output.
- R10: Outside a forwarded frame, `sdo` and `ld_out` are 0.
- R11: `frame_vld` and `frame_err` are single-clock pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sdi | input | 1 | Serial frame data in, MSB first |
| ld_in | input | 1 | Load strobe from the upstream stage |
| fault_hot | input | 1 | Local overtemperature fault |
| fault_open | input | 1 | Local open-LED fault |
| sdo | output | 1 | Serial frame data to the next stage |
| ld_out | output | 1 | Load strobe to the next stage |
| cmd_out | output | 2 | Decoded command C1:C0 of the last good frame |
| frame_vld | output | 1 | One-clock pulse when the local payload is complete |
| frame_err | output | 1 | One-clock pulse when a frame is dropped |
| pay_data | output | PAY_MAX | Local payload, right-aligned |

## Verification
The bench builds the stage with local payload lengths of 12, 8, 4 and 6 bits for the four commands. Frames stay under 50 bits, so every command, each strobe offset inside and just outside the window, a tally at its ceiling and a frame with no forwarded payload fit into a short run. Because the lengths differ, a wrong length mapping shows up as a shifted payload and a shifted forwarded stream.

// File: rtl/chs_pkg.sv
// Shared constants and types of the cascade header stage.
// Assumes MSB-first serial framing with a fixed 24-bit header.
package chs_pkg;
    localparam int HDR_W   = 24;
    localparam int SYNC_W  = 8;
    localparam int CMD_W   = 6;
    localparam int CNT_W   = HDR_W - SYNC_W - CMD_W;
    localparam logic [SYNC_W-1:0] SYNC_WORD = 8'hE8;
    // header clocks still to come after the sync-hit clock, minus one
    localparam int HDR_LOAD   = HDR_W - SYNC_W - 2;
    // drain clocks after the first strobe-low forwarding clock, minus one
    localparam int DRAIN_LOAD = HDR_W - 2;
    localparam int OUT_LD_AT  = SYNC_W;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_HDR,
        ST_CAP,
        ST_FWD,
        ST_DRAIN
    } chs_state_e;
endpackage

// File: rtl/chs_strobe_track.sv
// Keeps a short history of the load strobe.
// hist[0] is the strobe one clock back, hist[DEPTH-1] is DEPTH clocks back.
module chs_strobe_track #(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_in,
    output logic [DEPTH-1:0] hist
);
    // shift the strobe into the history register
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[DEPTH-2:0], ld_in};
    end
endmodule

// File: rtl/chs_delay_line.sv
// Serial delay line that also serves as the sync search window.
// A load overrides a shift; with neither the line holds its contents.
module chs_delay_line #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         din,
    output logic [W-1:0] win
);
    // load, shift or hold the window
    always_ff @(posedge clk) begin
        if (!rst_n)        win <= '0;
        else if (load_en)  win <= load_val;
        else if (shift_en) win <= {win[W-2:0], din};
    end
endmodule

// File: rtl/chs_hdr_eval.sv
// Combinational header check and rewrite.
// Checks that the three command copies agree, decodes C1:C0 and bumps the
// fault tally (saturating) when the fault picked by C0 is active.
module chs_hdr_eval
    import chs_pkg::*;
(
    input  logic [HDR_W-1:0] hdr_in,
    input  logic             fault_hot,
    input  logic             fault_open,
    output logic             cmd_good,
    output logic [1:0]       cmd,
    output logic [HDR_W-1:0] hdr_out
);
    logic [CMD_W-1:0] cf;
    logic [CNT_W-1:0] tally;
    logic             bump;

    // decode command copies and pick the fault source
    always_comb begin
        cf       = hdr_in[CNT_W +: CMD_W];
        tally    = hdr_in[CNT_W-1:0];
        cmd      = cf[5:4];
        cmd_good = (cf[5:4] == cf[3:2]) && (cf[3:2] == cf[1:0]);
        bump     = (cf[4] ? fault_open : fault_hot) && (tally != '1);
    end

    // rebuild the header with the updated tally
    always_comb begin
        hdr_out = {hdr_in[HDR_W-1:CNT_W], bump ? tally + CNT_W'(1) : tally};
    end
endmodule

// File: rtl/chs_payload.sv
// Local payload shift register, filled MSB first and right-aligned.
module chs_payload #(
    parameter int PAY_MAX = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               shift,
    input  logic               din,
    output logic [PAY_MAX-1:0] data
);
    // clear at frame start, shift in each local bit
    always_ff @(posedge clk) begin
        if (!rst_n)     data <= '0;
        else if (clr)   data <= '0;
        else if (shift) data <= {data[PAY_MAX-2:0], din};
    end
endmodule

// File: rtl/chain_header_stage.sv
// One stage of a serial daisy chain. It hunts for sync while the strobe is
// low, checks the strobe window and the command copies, bumps the fault
// tally, takes its own payload share and forwards the rest behind the header.
// Assumes at least 24 strobe-low clocks between frames.
module chain_header_stage
    import chs_pkg::*;
#(
    parameter int PAY_PWM = 96,
    parameter int PAY_CAL = 48,
    parameter int PAY_GLB = 24,
    parameter int PAY_CFG = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sdi,
    input  logic                ld_in,
    input  logic                fault_hot,
    input  logic                fault_open,
    output logic                sdo,
    output logic                ld_out,
    output logic [1:0]          cmd_out,
    output logic                frame_vld,
    output logic                frame_err,
    output logic [PAY_MAX-1:0]  pay_data
);
    localparam int PAY_A   = (PAY_PWM > PAY_CAL) ? PAY_PWM : PAY_CAL;
    localparam int PAY_B   = (PAY_GLB > PAY_CFG) ? PAY_GLB : PAY_CFG;
    localparam int PAY_MAX = (PAY_A > PAY_B) ? PAY_A : PAY_B;
    localparam int CAP_W   = $clog2(PAY_MAX + 1);
    localparam int HIST_D  = 3;

    chs_state_e        state;
    logic [HIST_D-1:0] hist;
    logic [HDR_W-1:0]  win, hdr_next, hdr_new;
    logic              ev_good;
    logic [1:0]        ev_cmd;
    logic [CAP_W-1:0]  ev_len, capcnt;
    logic [3:0]        hcnt;
    logic [4:0]        dcnt;
    logic [3:0]        ocnt;
    logic              sync_hit, hdr_last, load_hdr, out_en;

    chs_strobe_track #(.DEPTH(HIST_D)) u_strobe (
        .clk(clk), .rst_n(rst_n), .ld_in(ld_in), .hist(hist)
    );

    chs_delay_line #(.W(HDR_W)) u_line (
        .clk(clk), .rst_n(rst_n),
        .shift_en(state != ST_CAP), .load_en(load_hdr),
        .load_val(hdr_new), .din(sdi), .win(win)
    );

    chs_hdr_eval u_eval (
        .hdr_in(hdr_next), .fault_hot(fault_hot), .fault_open(fault_open),
        .cmd_good(ev_good), .cmd(ev_cmd), .hdr_out(hdr_new)
    );

    chs_payload #(.PAY_MAX(PAY_MAX)) u_pay (
        .clk(clk), .rst_n(rst_n), .clr(load_hdr),
        .shift(state == ST_CAP && ld_in), .din(sdi), .data(pay_data)
    );

    // header as it will stand after this clock's bit is shifted in
    always_comb hdr_next = {win[HDR_W-2:0], sdi};

    // frame start, header end and header commit conditions
    always_comb begin
        sync_hit = (state == ST_HUNT) && (win[SYNC_W-1:0] == SYNC_WORD)
                   && !hist[HIST_D-1];
        hdr_last = (state == ST_HDR) && (hcnt == 4'd0);
        load_hdr = hdr_last && ld_in && ev_good;
    end

    // local payload length for the decoded command
    always_comb begin
        case (ev_cmd)
            2'b00:   ev_len = CAP_W'(PAY_PWM);
            2'b01:   ev_len = CAP_W'(PAY_CAL);
            2'b10:   ev_len = CAP_W'(PAY_GLB);
            default: ev_len = CAP_W'(PAY_CFG);
        endcase
    end

    // frame sequencing, pulses and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HUNT;
            hcnt      <= '0;
            capcnt    <= '0;
            dcnt      <= '0;
            ocnt      <= '0;
            cmd_out   <= '0;
            frame_vld <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            frame_vld <= 1'b0;
            frame_err <= 1'b0;
            case (state)
                ST_HUNT: begin
                    if (sync_hit) begin
                        if (hist[HIST_D-2]) begin
                            frame_err <= 1'b1;
                        end else begin
                            state <= ST_HDR;
                            hcnt  <= 4'(HDR_LOAD);
                        end
                    end
                end
                ST_HDR: begin
                    if (!ld_in || (hdr_last && !ev_good)) begin
                        frame_err <= 1'b1;
                        state     <= ST_HUNT;
                    end else if (hdr_last) begin
                        state   <= ST_CAP;
                        cmd_out <= ev_cmd;
                        capcnt  <= ev_len - CAP_W'(1);
                    end else begin
                        hcnt <= hcnt - 4'd1;
                    end
                end
                ST_CAP: begin
                    if (!ld_in) begin
                        frame_err <= 1'b1;
                        state     <= ST_HUNT;
                    end else if (capcnt == '0) begin
                        frame_vld <= 1'b1;
                        state     <= ST_FWD;
                        ocnt      <= '0;
                    end else begin
                        capcnt <= capcnt - CAP_W'(1);
                    end
                end
                ST_FWD: begin
                    if (ocnt != 4'(OUT_LD_AT)) ocnt <= ocnt + 4'd1;
                    if (!ld_in) begin
                        state <= ST_DRAIN;
                        dcnt  <= 5'(DRAIN_LOAD);
                    end
                end
                ST_DRAIN: begin
                    if (ocnt != 4'(OUT_LD_AT)) ocnt <= ocnt + 4'd1;
                    if (dcnt == 5'd0) state <= ST_HUNT;
                    else              dcnt  <= dcnt - 5'd1;
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    // forwarded data and strobe
    always_comb begin
        out_en = (state == ST_FWD) || (state == ST_DRAIN);
        sdo    = out_en && win[HDR_W-1];
        ld_out = out_en && (ocnt == 4'(OUT_LD_AT));
    end
endmodule

// File: rtl/chs_checker.sv
// Protocol checker bound to the cascade header stage; observes ports only.
module chs_checker (
    input logic clk,
    input logic rst_n,
    input logic frame_vld,
    input logic frame_err,
    input logic sdo,
    input logic ld_out
);
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_vld && frame_err)); // R11
    AST_VLD_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld); // R11
    AST_HDR_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |-> sdo); // R7
    AST_LDOUT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ld_out) |-> $past(frame_vld, 8)); // R8
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> (!ld_out && !sdo)); // R9
endmodule

bind chain_header_stage chs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld),
    .frame_err(frame_err), .sdo(sdo), .ld_out(ld_out)
);

// File: tb/chain_header_stage_tb.sv
module chain_header_stage_tb;
    localparam int CLK_P = 10;
    localparam int NP = 12, NC = 8, NG = 4, NF = 6;
    localparam int PM = 12;

    logic clk = 1'b0, rst_n = 1'b0, sdi = 1'b0, ld_in = 1'b0;
    logic fault_hot = 1'b0, fault_open = 1'b0;
    logic sdo, ld_out, frame_vld, frame_err;
    logic [1:0] cmd_out;
    logic [PM-1:0] pay_data;

    int n_run = 0, n_fail = 0, idle_bad = 0, excl_bad = 0, unexp = 0;
    bit done = 0;

    typedef struct {
        int          kind;
        logic [1:0]  cmd;
        logic [PM-1:0] pay;
        logic [127:0] fwd;
        int          flen;
        string       tag;
    } exp_t;
    exp_t sb[$];

    chain_header_stage #(.PAY_PWM(NP), .PAY_CAL(NC), .PAY_GLB(NG), .PAY_CFG(NF)) u_dut (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .ld_in(ld_in),
        .fault_hot(fault_hot), .fault_open(fault_open), .sdo(sdo),
        .ld_out(ld_out), .cmd_out(cmd_out), .frame_vld(frame_vld),
        .frame_err(frame_err), .pay_data(pay_data)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp_v);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // driver: pushes the expected outcome, then drives the frame
    task automatic send_frame(input logic [5:0] cf, input logic [9:0] cnt,
                              input int nd, input logic [63:0] data,
                              input int rise, input int drop,
                              input logic fh, input logic fo,
                              input int kind, input string tag);
        exp_t e;
        logic [23:0] hdr;
        logic [9:0] ncnt;
        int n;
        logic sel;
        hdr = {8'hE8, cf, cnt};
        case (cf[5:4])
            2'b00: n = NP;
            2'b01: n = NC;
            2'b10: n = NG;
            default: n = NF;
        endcase
        sel  = cf[4] ? fo : fh;
        ncnt = (sel && cnt != 10'h3FF) ? cnt + 10'd1 : cnt;
        e.kind = kind; e.cmd = cf[5:4]; e.tag = tag;
        e.pay  = PM'((data >> (nd - n)) & ((64'd1 << n) - 64'd1));
        e.flen = 24 + nd - n;
        e.fwd  = '0;
        for (int k = 0; k < 24; k++) e.fwd[e.flen-1-k] = (k < 14) ? hdr[23-k] : ncnt[23-k];
        for (int k = 0; k < nd - n; k++) e.fwd[nd-n-1-k] = data[nd-n-1-k];
        if (kind != 0) sb.push_back(e);
        fault_hot = fh; fault_open = fo;
        for (int i = -4; i < nd + 24; i++) begin
            @(posedge clk); #1;
            ld_in = (i >= rise) && (drop < 0 || i < drop);
            if (drop >= 0 && i >= drop) sdi = 1'b0;
            else sdi = (i < 0) ? 1'b0 : (i < 24) ? hdr[23-i] : data[nd-1-(i-24)];
        end
        for (int i = 0; i < 30; i++) begin
            @(posedge clk); #1;
            ld_in = 1'b0; sdi = 1'b0;
        end
    endtask

    // monitor: pops expectations as results appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (frame_vld && frame_err) excl_bad++;
                if (frame_vld || frame_err) begin
                    if (sb.size() == 0) begin
                        unexp++;
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        if (frame_err) begin
                            chk(e.kind == 2, {e.tag, " frame_err"}, 128'(e.kind), 128'd2);
                        end else begin
                            int bad_d, bad_l;
                            chk(e.kind == 1, {e.tag, " frame_vld"}, 128'(e.kind), 128'd1);
                            chk(cmd_out == e.cmd, "R5 cmd_out", 128'(cmd_out), 128'(e.cmd));
                            chk(pay_data == e.pay, "R5 pay_data", 128'(pay_data), 128'(e.pay));
                            bad_d = 0; bad_l = 0;
                            for (int k = 0; k < e.flen; k++) begin
                                if (k > 0) @(negedge clk);
                                if (sdo !== e.fwd[e.flen-1-k]) bad_d++;
                                if (ld_out !== (k >= 8)) bad_l++;
                            end
                            chk(bad_d == 0, {e.tag, " R7 forwarded bits"}, 128'(bad_d), 128'd0);
                            chk(bad_l == 0, "R8 ld_out window", 128'(bad_l), 128'd0);
                            @(negedge clk);
                            chk(!sdo && !ld_out, "R8 ld_out end", 128'({sdo, ld_out}), 128'd0);
                        end
                    end
                end else if (sdo || ld_out) begin
                    idle_bad++;
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!sdo && !ld_out && !frame_vld && !frame_err && cmd_out == 2'b00,
            "R1 reset state", 128'({sdo, ld_out, frame_vld, frame_err, cmd_out}), 128'd0);
        // R5 R7 on-time strobe, PWM, no fault
        send_frame(6'b000000, 10'd0, 22, 64'h2A5A95, 8, -1, 1'b0, 1'b0, 1, "R5");
        // R3 early strobe accepted, R6 open fault counted
        send_frame(6'b010101, 10'd5, 14, 64'h25A6, 7, -1, 1'b0, 1'b1, 1, "R3 R6 early");
        // R3 late strobe accepted, R6 saturation at 1023
        send_frame(6'b101010, 10'h3FF, 10, 64'h2B5, 9, -1, 1'b1, 1'b0, 1, "R3 R6 sat");
        // R6 C0=1 selects open fault, hot fault ignored
        send_frame(6'b111111, 10'd7, 12, 64'hA5A, 8, -1, 1'b1, 1'b0, 1, "R6 sel open");
        // R6 C0=0 selects hot fault, open fault ignored
        send_frame(6'b101010, 10'd3, 9, 64'h14B, 8, -1, 1'b0, 1'b1, 1, "R6 sel hot");
        // R7 no payload left to forward: header only
        send_frame(6'b011010, 10'd0, 8, 64'h5A, 8, -1, 1'b0, 1'b0, 2, "R4 mismatch");
        send_frame(6'b010101, 10'd2, 8, 64'h5A, 8, -1, 1'b1, 1'b1, 1, "R7 header only");
        // R3 strobe edges outside window
        send_frame(6'b000000, 10'd0, 16, 64'h5A5A, 6, -1, 1'b0, 1'b0, 2, "R3 too early");
        send_frame(6'b000000, 10'd0, 16, 64'h5A5A, 10, -1, 1'b0, 1'b0, 2, "R3 too late");
        // R9 strobe drop during local capture
        send_frame(6'b000000, 10'd0, 20, 64'h5A5A5, 8, 28, 1'b0, 1'b0, 2, "R9 drop");
        // R2 strobe already high through sync: ignored
        send_frame(6'b000000, 10'd0, 16, 64'h5A5A, -3, -1, 1'b0, 1'b0, 0, "R2");
        send_frame(6'b101010, 10'd9, 6, 64'h2A, 8, -1, 1'b0, 1'b0, 1, "R2 recovery");
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk(sb.size() == 0, "R2 pending expectations", 128'(sb.size()), 128'd0);
        chk(unexp == 0, "R2 unexpected frame events", 128'(unexp), 128'd0);
        chk(idle_bad == 0, "R10 idle output", 128'(idle_bad), 128'd0);
        chk(excl_bad == 0, "R11 pulse overlap", 128'(excl_bad), 128'd0);
        done = 1;
        summary();
    end
endmodule